// File: doc/BRIEF.md
# Drift-Corrected Hardware Time Counter

This block keeps a 64-bit nanosecond count for a network timestamping unit. A strobe from a nominal 16 ns time base advances the count by one quantum. A drift counter trims the rate. After a programmable number of quanta it inserts one extra step of 0 to 7 ns, added or taken away, so that slow or fast reference oscillators can be corrected without a fractional accumulator.

Software reaches the block through a simple register port. It can pause and resume the count, load a new 64-bit value in two 32-bit halves while the count is paused, and program a packed drift word behind a drift-reset interlock. It can also read the live time in two halves. Reading the low half freezes the high half of that same instant, so the two halves always belong together.

Top module: `drift_time_counter`

## Requirements
- R1: After a synchronous active-low reset, the time reads zero, the count runs (not paused), the drift word reads zero and the drift-reset bit reads zero.
- R2: On each cycle with the tick strobe high, the count running and no drift event, the time grows by exactly 16. Without a tick the time does not change.
- R3: The drift word at address 3 holds the period in bits [27:0], the step magnitude in bits [30:28] and the direction in bit 31 (1 adds, 0 subtracts). On a drift event tick the time grows by 16 plus the magnitude, or by 16 minus the magnitude.
- R4: Running ticks are counted from the moment drift operation starts. A drift event falls on every tick whose count since the last restart reaches the period, and the count restarts after each event.
- R5: A write of the drift word is accepted only while the drift-reset bit (address 4, bit 0) is 1, and is ignored otherwise. Reading address 4 returns that bit. Clearing the bit starts drift operation with the interval count at zero.
- R6: A period of zero or a magnitude of zero gives no correction: the time grows by 16 per tick.
- R7: Writing 2 to the control register (address 0) pauses the count, and writing 4 resumes it. Other values are ignored. While paused, ticks leave the time and the drift interval count unchanged.
- R8: Writes of the load value (low half at address 1, high half at address 2) are accepted only while paused. A resume that follows such a write sets the time to the loaded value in the resume cycle. A resume with no load pending continues from the held time.
- R9: The read data appears on the cycle after a read request. Address 3 returns the drift word, address 4 the drift-reset bit, address 5 the low half of the time, and address 6 the high half captured by the last low-half read. Any other address returns zero.
- R10: A low-half read in the same cycle as a tick (with or without a drift event) captures the time before that tick is applied, in both halves.
- R11: While the drift-reset bit is 1, no drift event occurs and each running tick adds exactly 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe per 16 ns of nominal time |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Read data, valid the cycle after the request |
| time_o | output | 64 | Live nanosecond time |

## Verification
The low-half snapshot read can land in the same cycle as a tick, and that tick may also carry a drift step. The bench sets a period of 2 and lines up a read of address 5 with the tick that completes the interval. It expects both halves to show the time from just before that edge, and the live time to have moved by 16 plus the magnitude. The resume command can also coincide with a tick. There the loaded value must win and the tick must be lost. A reference model written in the bench judges both cases on every clock.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int TIME_W     = 64;
  localparam int HALF_W     = 32;
  localparam int PER_W      = 28;
  localparam int MAG_W      = 3;
  localparam int ADDR_W     = 3;
  localparam int QUANTUM_NS = 16;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_LD_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_LD_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_DRIFT = 3'd3;
  localparam logic [ADDR_W-1:0] A_DRST  = 3'd4;
  localparam logic [ADDR_W-1:0] A_T_LO  = 3'd5;
  localparam logic [ADDR_W-1:0] A_T_HI  = 3'd6;

  localparam logic [HALF_W-1:0] CMD_PAUSE  = 32'd2;
  localparam logic [HALF_W-1:0] CMD_RESUME = 32'd4;

  typedef struct packed {
    logic             add;
    logic [MAG_W-1:0] mag;
    logic [PER_W-1:0] period;
  } drift_cfg_t;

  function automatic logic drift_active(input drift_cfg_t c);
    return (c.period != '0) && (c.mag != '0);
  endfunction

  function automatic logic [TIME_W-1:0] advance(input logic [TIME_W-1:0] cur,
                                                input logic evt,
                                                input drift_cfg_t c,
                                                input int unsigned quantum);
    logic [TIME_W-1:0] step;
    step = TIME_W'(quantum);
    if (evt) begin
      if (c.add) step = step + TIME_W'(c.mag);
      else       step = step - TIME_W'(c.mag);
    end
    return cur + step;
  endfunction
endpackage

// File: rtl/dtc_regs.sv
module dtc_regs
  import dtc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [HALF_W-1:0]   wr_data,
  output logic                paused,
  output drift_cfg_t          cfg,
  output logic                drift_rst,
  output logic [TIME_W-1:0]   load_val,
  output logic                resume_load
);
  localparam int N_HALF = TIME_W / HALF_W;

  logic pause_cmd, resume_cmd, cfg_wr, drst_wr, ld_any, ld_pend;
  logic [N_HALF-1:0] ld_wr;
  logic [N_HALF-1:0][HALF_W-1:0] ld_half;

  always_comb begin
    pause_cmd   = wr_en && (wr_addr == A_CTRL) && (wr_data == CMD_PAUSE);
    resume_cmd  = wr_en && (wr_addr == A_CTRL) && (wr_data == CMD_RESUME);
    cfg_wr      = wr_en && (wr_addr == A_DRIFT);
    drst_wr     = wr_en && (wr_addr == A_DRST);
    resume_load = resume_cmd && paused && ld_pend;
  end

  for (genvar h = 0; h < N_HALF; h++) begin : g_ld
    assign ld_wr[h] = wr_en && paused && (wr_addr == ADDR_W'(int'(A_LD_LO) + h));
    always_ff @(posedge clk) begin
      if (!rst_n)      ld_half[h] <= '0;
      else if (ld_wr[h]) ld_half[h] <= wr_data;
    end
  end
  assign ld_any   = |ld_wr;
  assign load_val = ld_half;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      paused    <= 1'b0;
      cfg       <= '0;
      drift_rst <= 1'b0;
      ld_pend   <= 1'b0;
    end else begin
      if (pause_cmd)  paused <= 1'b1;
      if (resume_cmd) paused <= 1'b0;
      if (resume_cmd)  ld_pend <= 1'b0;
      else if (ld_any) ld_pend <= 1'b1;
      if (cfg_wr && drift_rst) cfg <= drift_cfg_t'(wr_data);
      if (drst_wr) drift_rst <= wr_data[0];
    end
  end

  // R7
  pause_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause_cmd |=> paused);
  // R5
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !drift_rst) |=> $stable(cfg));
  // R8
  load_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !paused) |=> $stable(load_val));
endmodule

// File: rtl/dtc_drift.sv
module dtc_drift
  import dtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_run,
  input  drift_cfg_t cfg,
  input  logic       drift_rst,
  output logic       drift_evt
);
  logic [PER_W-1:0] dcnt;
  logic             active;

  always_comb begin
    active    = drift_active(cfg) && !drift_rst;
    drift_evt = active && tick_run && (dcnt == cfg.period - PER_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !active) dcnt <= '0;
    else if (tick_run)     dcnt <= drift_evt ? '0 : dcnt + PER_W'(1);
  end

  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drift_rst |=> (dcnt == '0));
  // R4
  interval_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (dcnt < cfg.period));
  // R11
  no_evt_in_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(drift_rst) && drift_rst |-> !drift_evt);
endmodule

// File: rtl/dtc_timebase.sv
module dtc_timebase
  import dtc_pkg::*;
#(
  parameter int unsigned QUANTUM = QUANTUM_NS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              paused,
  input  logic              drift_evt,
  input  drift_cfg_t        cfg,
  input  logic              drift_rst,
  input  logic              resume_load,
  input  logic [TIME_W-1:0] load_val,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [HALF_W-1:0] rd_data,
  output logic [TIME_W-1:0] time_o
);
  logic [HALF_W-1:0] snap_hi;
  logic              snap_rd;

  assign snap_rd = rd_en && (rd_addr == A_T_LO);

  always_ff @(posedge clk) begin
    if (!rst_n)              time_o <= '0;
    else if (resume_load)    time_o <= load_val;
    else if (tick && !paused) time_o <= advance(time_o, drift_evt, cfg, QUANTUM);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      snap_hi <= '0;
    end else begin
      rd_data <= '0;
      if (snap_rd) snap_hi <= time_o[TIME_W-1:HALF_W];
      if (rd_en) begin
        case (rd_addr)
          A_DRIFT: rd_data <= cfg;
          A_DRST:  rd_data <= HALF_W'(drift_rst);
          A_T_LO:  rd_data <= time_o[HALF_W-1:0];
          A_T_HI:  rd_data <= snap_hi;
          default: rd_data <= '0;
        endcase
      end
    end
  end

  // R7
  hold_when_paused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !resume_load) |=> $stable(time_o));
  // R2
  plain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !paused && !drift_evt) |=> (time_o == $past(time_o) + TIME_W'(QUANTUM)));
  // R8
  load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_load |=> (time_o == $past(load_val)));
  // R10
  snap_pre_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_rd |=> (rd_data == $past(time_o[HALF_W-1:0])) && (snap_hi == $past(time_o[TIME_W-1:HALF_W])));
endmodule

// File: rtl/drift_time_counter.sv
module drift_time_counter
  import dtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              rd_en_i,
  input  logic [2:0]        rd_addr_i,
  output logic [31:0]       rd_data_o,
  output logic [63:0]       time_o
);
  logic              paused, drift_rst, resume_load, drift_evt, tick_run;
  drift_cfg_t        cfg;
  logic [TIME_W-1:0] load_val;

  assign tick_run = tick_i && !paused;

  dtc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .paused(paused), .cfg(cfg), .drift_rst(drift_rst),
    .load_val(load_val), .resume_load(resume_load)
  );

  dtc_drift u_drift (
    .clk(clk), .rst_n(rst_n), .tick_run(tick_run), .cfg(cfg),
    .drift_rst(drift_rst), .drift_evt(drift_evt)
  );

  dtc_timebase #(.QUANTUM(QUANTUM_NS)) u_time (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .paused(paused),
    .drift_evt(drift_evt), .cfg(cfg), .drift_rst(drift_rst),
    .resume_load(resume_load), .load_val(load_val), .rd_en(rd_en_i),
    .rd_addr(rd_addr_i), .rd_data(rd_data_o), .time_o(time_o)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (time_o == '0) && !paused && (cfg == '0) && !drift_rst);
endmodule

// File: tb/drift_time_counter_test.sv
module drift_time_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [63:0] time_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  drift_time_counter uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .time_o(time_o)
  );

  // behavioural reference model
  longint unsigned m_time, m_ld, m_snap;
  bit          m_paused, m_drst, m_ldp;
  bit [31:0]   m_cfg, m_rd;
  int unsigned m_dc;

  always begin : model
    int unsigned per, mg;
    bit ad, run, on, ev;
    @(posedge clk);
    if (!rst_n) begin
      m_time = 0; m_ld = 0; m_snap = 0; m_paused = 0; m_drst = 0;
      m_ldp = 0; m_cfg = 0; m_rd = 0; m_dc = 0;
    end else begin
      per = m_cfg & 32'h0FFF_FFFF;
      mg  = (m_cfg >> 28) & 7;
      ad  = m_cfg[31];
      run = tick && !m_paused;
      on  = !m_drst && per != 0 && mg != 0;
      ev  = on && run && (m_dc + 1 == per);
      m_rd = 0;
      if (rd_en) begin
        if (rd_addr == 3) m_rd = m_cfg;
        else if (rd_addr == 4) m_rd = {31'd0, m_drst};
        else if (rd_addr == 5) begin m_rd = m_time[31:0]; m_snap = m_time; end
        else if (rd_addr == 6) m_rd = m_snap[63:32];
      end
      if (wr_en && wr_addr == 0 && wr_data == 4 && m_paused && m_ldp) m_time = m_ld;
      else if (run) begin
        m_time = m_time + 16;
        if (ev) m_time = ad ? m_time + 64'(mg) : m_time - 64'(mg);
      end
      if (!on) m_dc = 0;
      else if (run) m_dc = ev ? 0 : m_dc + 1;
      if (wr_en) begin
        case (wr_addr)
          3'd0: if (wr_data == 2) m_paused = 1;
                else if (wr_data == 4) begin m_paused = 0; m_ldp = 0; end
          3'd1: if (m_paused) begin m_ld[31:0] = wr_data; m_ldp = 1; end
          3'd2: if (m_paused) begin m_ld[63:32] = wr_data; m_ldp = 1; end
          3'd3: if (m_drst) m_cfg = wr_data;
          3'd4: m_drst = wr_data[0];
          default: ;
        endcase
      end
    end
    #5;
    checks++;
    if (time_o !== m_time) begin
      errors++;
      $display("FAIL %s time_o actual %h expected %h", cur_req, time_o, m_time);
    end
    checks++;
    if (rd_data !== m_rd) begin
      errors++;
      $display("FAIL %s rd_data actual %h expected %h", cur_req, rd_data, m_rd);
    end
  end

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input bit with_tick, output logic [31:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a; tick = with_tick;
    @(negedge clk); d = rd_data; rd_en = 0; tick = 0;
  endtask

  task automatic run_ticks(input int n);
    repeat (n) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired in %s", cur_req);
    summary();
  end

  initial begin : stim
    logic [31:0] d, lo, hi;
    logic [63:0] t0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    chk("R1", time_o, 64'd0);
    rd(3'd3, 0, d); chk("R1", {32'd0, d}, 64'd0);
    rd(3'd4, 0, d); chk("R1", {32'd0, d}, 64'd0);
    rd(3'd5, 0, d); chk("R1", {32'd0, d}, 64'd0);
    // R2 plain ticks
    cur_req = "R2";
    run_ticks(20);
    chk("R2", time_o, 64'd320);
    repeat (5) @(negedge clk);
    chk("R2", time_o, 64'd320);
    // R5 drift word ignored without the interlock
    cur_req = "R5";
    wr(3'd3, 32'h3000_0005);
    rd(3'd3, 0, d); chk("R5", {32'd0, d}, 64'd0);
    wr(3'd4, 32'd1);
    rd(3'd4, 0, d); chk("R5", {32'd0, d}, 64'd1);
    wr(3'd3, {1'b1, 3'd3, 28'd5});
    rd(3'd3, 0, d); chk("R5", {32'd0, d}, {32'd0, 1'b1, 3'd3, 28'd5});
    wr(3'd4, 32'd0);
    // R3 R4 add by 3 every 5 ticks
    cur_req = "R4";
    t0 = time_o;
    run_ticks(50);
    chk("R4", time_o - t0, 64'd830);
    // R3 subtract 7 every 4 ticks
    cur_req = "R3";
    wr(3'd4, 32'd1); wr(3'd3, {1'b0, 3'd7, 28'd4}); wr(3'd4, 32'd0);
    t0 = time_o;
    run_ticks(40);
    chk("R3", time_o - t0, 64'd570);
    // R6 magnitude zero, maximal period
    cur_req = "R6";
    wr(3'd4, 32'd1); wr(3'd3, {1'b1, 3'd0, 28'hFFF_FFFF}); wr(3'd4, 32'd0);
    t0 = time_o; run_ticks(30);
    chk("R6", time_o - t0, 64'd480);
    wr(3'd4, 32'd1); wr(3'd3, {1'b1, 3'd5, 28'd0}); wr(3'd4, 32'd0);
    t0 = time_o; run_ticks(30);
    chk("R6", time_o - t0, 64'd480);
    // R11 drift held in reset
    cur_req = "R11";
    wr(3'd4, 32'd1); wr(3'd3, {1'b1, 3'd7, 28'd3});
    t0 = time_o; run_ticks(20);
    chk("R11", time_o - t0, 64'd320);
    // R7 pause, ignored command, resume
    cur_req = "R7";
    wr(3'd0, 32'd2);
    t0 = time_o; run_ticks(10);
    chk("R7", time_o, t0);
    wr(3'd0, 32'd3);
    run_ticks(4);
    chk("R7", time_o, t0);
    wr(3'd0, 32'd4);
    run_ticks(2);
    chk("R7", time_o - t0, 64'd32);
    // R8 loads ignored while running, applied at resume while paused
    cur_req = "R8";
    wr(3'd1, 32'hDEAD_0000); wr(3'd2, 32'h0000_0099);
    t0 = time_o;
    wr(3'd0, 32'd2); wr(3'd0, 32'd4);
    chk("R8", time_o, t0);
    wr(3'd0, 32'd2);
    wr(3'd1, 32'hFFFF_FFF0); wr(3'd2, 32'h0000_0001);
    run_ticks(3);
    chk("R8", time_o, t0);
    @(negedge clk); wr_en = 1; wr_addr = 3'd0; wr_data = 32'd4; tick = 1;
    @(negedge clk); wr_en = 0; tick = 0;
    chk("R8", time_o, 64'h1_FFFF_FFF0);
    run_ticks(1);
    chk("R8", time_o, 64'h2_0000_0000);
    // R9 R10 snapshot read colliding with a drift tick
    cur_req = "R10";
    wr(3'd3, {1'b1, 3'd5, 28'd2}); wr(3'd4, 32'd0);
    run_ticks(1);
    t0 = time_o;
    rd(3'd5, 1, lo);
    chk("R10", time_o - t0, 64'd21);
    rd(3'd6, 0, hi);
    chk("R10", {hi, lo}, t0);
    cur_req = "R9";
    rd(3'd7, 0, d); chk("R9", {32'd0, d}, 64'd0);
    run_ticks(7);
    t0 = time_o;
    rd(3'd5, 0, lo); rd(3'd6, 0, hi);
    chk("R9", {hi, lo}, t0);
    // R1 reset mid-run
    cur_req = "R1";
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R1", time_o, 64'd0);
    rd(3'd4, 0, d); chk("R1", {32'd0, d}, 64'd0);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule